// File: doc/BRIEF.md
# Memory Wait Counter Scoreboard

This block keeps count of the memory operations that one wavefront has in flight and holds instruction issue while a wait instruction asks for fewer outstanding operations than are pending. Two counts are kept. The shared count covers scalar loads and local-data-store accesses together. The vector count covers vector memory loads and stores. An issue pulse on a class raises its count. A return pulse lowers it once the data for one operation of that class has landed.

A wait is presented as a level on `wait_valid_i` with one threshold per count. `stall_o` is combinational and stays high while any count that is being waited on lies above its threshold. The all-ones threshold disables the wait on that count. Vector and local-data-store operations retire in issue order. Scalar loads can retire in any order, so any unfinished scalar load makes the shared wait behave as a wait for zero. Counts saturate at their maximum. An issue that would overflow is refused and raises `stall_o` so that the issuer retries. A return with nothing outstanding is dropped and sets a sticky error flag.

Top module: `wcnt_scoreboard`

## Requirements
- R1: An accepted issue pulse raises its count by one at the next clock edge. Scalar and local-data-store issues raise `shared_cnt_o`. Vector issues raise `vmem_cnt_o`.
- R2: A return pulse lowers its count by one at the next edge. An accepted issue and a counted return for the same count in one cycle leave that count unchanged.
- R3: Scalar and local-data-store operations share one count. Issues of both classes in one cycle raise `shared_cnt_o` by two and leave `vmem_cnt_o` unchanged.
- R4: While `wait_valid_i` is high, `stall_o` is high in any cycle where a count lies above its effective threshold. It is low when every count lies at or below its threshold and no issue is refused.
- R5: A threshold of all ones (63 at the default width) means no wait on that count.
- R6: While at least one scalar load is outstanding, the shared threshold is treated as zero, unless it is all ones.
- R7: Counts are 6 bits wide. If accepting the issues of a count would carry it past 63, neither issue on that count is accepted. The count does not wrap, and `stall_o` is high in that cycle.
- R8: A return pulse whose class has nothing outstanding is ignored, so the count does not change. It sets `err_o`, which stays high until reset.
- R9: Reset (`rst_ni` low) clears both counts and `err_o`. `stall_o` is low after reset while no wait is requested.
- R10: While `wait_valid_i` is low, `stall_o` is high only when an issue is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scalar_issue_i | input | 1 | Scalar load dispatched |
| lds_issue_i | input | 1 | Local-data-store access dispatched |
| vmem_issue_i | input | 1 | Vector memory load or store dispatched |
| scalar_ret_i | input | 1 | One scalar load completed |
| lds_ret_i | input | 1 | One local-data-store access completed |
| vmem_ret_i | input | 1 | One vector memory operation completed |
| wait_valid_i | input | 1 | Wait instruction active |
| wait_shared_thr_i | input | 6 | Shared-count threshold; all ones means no wait |
| wait_vmem_thr_i | input | 6 | Vector-count threshold; all ones means no wait |
| stall_o | output | 1 | Hold instruction issue |
| err_o | output | 1 | Sticky flag: a return arrived with nothing outstanding |
| shared_cnt_o | output | 6 | Outstanding scalar plus local-data-store operations |
| vmem_cnt_o | output | 6 | Outstanding vector memory operations |

## Verification
A wrong count appears on the count outputs one edge after the pulse that caused it. It also moves the threshold at which `stall_o` falls for any later wait. An error in the scalar-pending tracking shows only when a wait is active: `stall_o` falls early while a scalar load is still out, in the same cycle the wait is compared. A missed saturation shows as a count that drops from 63 to 0 at the edge after the refused issue, and as a low `stall_o` in the issue cycle itself.

// File: rtl/wcnt_pkg.sv
package wcnt_pkg;
  typedef enum logic [1:0] {
    SRC_SCALAR = 2'd0,
    SRC_LDS    = 2'd1,
    SRC_VMEM   = 2'd2
  } src_e;

  localparam int unsigned NUM_SRC = 3;

  typedef struct packed {
    logic issue;
    logic ret;
  } mem_ev_t;
endpackage

// File: rtl/wcnt_counter.sv
module wcnt_counter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ret_i,
  output logic [W-1:0] cnt_o,
  output logic         ret_ok_o,
  output logic         ret_bad_o
);
  logic [W-1:0] cnt_q;

  assign ret_ok_o  = ret_i & (cnt_q != '0);
  assign ret_bad_o = ret_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (inc_i && !ret_ok_o) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!inc_i && ret_ok_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wcnt_admit.sv
module wcnt_admit #(
  parameter int unsigned W  = 6,
  parameter int unsigned CW = W + 1
) (
  input  logic [CW-1:0] cur_i,
  input  logic [1:0]    inc_i,
  input  logic [1:0]    dec_i,
  output logic          accept_o,
  output logic          block_o
);
  localparam int unsigned XW = CW + 2;
  localparam logic [XW-1:0] MAX_X = XW'((1 << W) - 1);

  logic [XW-1:0] next_x;

  // dec never exceeds cur, so no underflow
  assign next_x   = XW'(cur_i) + XW'(inc_i) - XW'(dec_i);
  assign accept_o = (next_x <= MAX_X);
  assign block_o  = (inc_i != 2'd0) & ~accept_o;
endmodule

// File: rtl/wcnt_stall.sv
module wcnt_stall #(
  parameter int unsigned W = 6
) (
  input  logic         wait_valid_i,
  input  logic [W-1:0] shared_thr_i,
  input  logic [W-1:0] vmem_thr_i,
  input  logic [W-1:0] shared_cnt_i,
  input  logic [W-1:0] vmem_cnt_i,
  input  logic         scalar_pend_i,
  input  logic         shared_block_i,
  input  logic         vmem_block_i,
  output logic         stall_o
);
  localparam logic [W-1:0] NO_WAIT = '1;

  logic [W-1:0] shared_eff;
  logic         shared_wait, vmem_wait;

  // out-of-order scalar returns: only a zero wait is exact
  assign shared_eff  = scalar_pend_i ? '0 : shared_thr_i;
  assign shared_wait = (shared_thr_i != NO_WAIT) & (shared_cnt_i > shared_eff);
  assign vmem_wait   = (vmem_thr_i != NO_WAIT) & (vmem_cnt_i > vmem_thr_i);

  assign stall_o = shared_block_i | vmem_block_i |
                   (wait_valid_i & (shared_wait | vmem_wait));
endmodule

// File: rtl/wcnt_scoreboard.sv
module wcnt_scoreboard #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scalar_issue_i,
  input  logic         lds_issue_i,
  input  logic         vmem_issue_i,
  input  logic         scalar_ret_i,
  input  logic         lds_ret_i,
  input  logic         vmem_ret_i,
  input  logic         wait_valid_i,
  input  logic [W-1:0] wait_shared_thr_i,
  input  logic [W-1:0] wait_vmem_thr_i,
  output logic         stall_o,
  output logic         err_o,
  output logic [W-1:0] shared_cnt_o,
  output logic [W-1:0] vmem_cnt_o
);
  import wcnt_pkg::*;

  localparam int unsigned CW = W + 1;

  mem_ev_t [NUM_SRC-1:0] ev;
  logic    [NUM_SRC-1:0] acc, ret_ok, ret_bad;
  logic    [W-1:0]       cnt [NUM_SRC];
  logic                  shared_acc, shared_blk, vmem_acc, vmem_blk;
  logic                  err_q;

  assign ev[SRC_SCALAR] = '{issue: scalar_issue_i, ret: scalar_ret_i};
  assign ev[SRC_LDS]    = '{issue: lds_issue_i,    ret: lds_ret_i};
  assign ev[SRC_VMEM]   = '{issue: vmem_issue_i,   ret: vmem_ret_i};

  assign acc[SRC_SCALAR] = ev[SRC_SCALAR].issue & shared_acc;
  assign acc[SRC_LDS]    = ev[SRC_LDS].issue & shared_acc;
  assign acc[SRC_VMEM]   = ev[SRC_VMEM].issue & vmem_acc;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cnt
    wcnt_counter #(.W(W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (acc[i]),
      .ret_i    (ev[i].ret),
      .cnt_o    (cnt[i]),
      .ret_ok_o (ret_ok[i]),
      .ret_bad_o(ret_bad[i])
    );
  end

  logic [CW-1:0] shared_sum;
  assign shared_sum = CW'(cnt[SRC_SCALAR]) + CW'(cnt[SRC_LDS]);

  wcnt_admit #(.W(W), .CW(CW)) u_adm_shared (
    .cur_i   (shared_sum),
    .inc_i   (2'(ev[SRC_SCALAR].issue) + 2'(ev[SRC_LDS].issue)),
    .dec_i   (2'(ret_ok[SRC_SCALAR]) + 2'(ret_ok[SRC_LDS])),
    .accept_o(shared_acc),
    .block_o (shared_blk)
  );

  wcnt_admit #(.W(W), .CW(CW)) u_adm_vmem (
    .cur_i   (CW'(cnt[SRC_VMEM])),
    .inc_i   (2'(ev[SRC_VMEM].issue)),
    .dec_i   (2'(ret_ok[SRC_VMEM])),
    .accept_o(vmem_acc),
    .block_o (vmem_blk)
  );

  // admission keeps the sum within W bits
  assign shared_cnt_o = shared_sum[W-1:0];
  assign vmem_cnt_o   = cnt[SRC_VMEM];

  wcnt_stall #(.W(W)) u_stall (
    .wait_valid_i  (wait_valid_i),
    .shared_thr_i  (wait_shared_thr_i),
    .vmem_thr_i    (wait_vmem_thr_i),
    .shared_cnt_i  (shared_cnt_o),
    .vmem_cnt_i    (vmem_cnt_o),
    .scalar_pend_i (cnt[SRC_SCALAR] != '0),
    .shared_block_i(shared_blk),
    .vmem_block_i  (vmem_blk),
    .stall_o       (stall_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (|ret_bad) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/wcnt_scoreboard_chk.sv
module wcnt_scoreboard_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scalar_issue_i,
  input logic         lds_issue_i,
  input logic         vmem_issue_i,
  input logic         scalar_ret_i,
  input logic         lds_ret_i,
  input logic         vmem_ret_i,
  input logic         wait_valid_i,
  input logic [W-1:0] wait_shared_thr_i,
  input logic [W-1:0] wait_vmem_thr_i,
  input logic         stall_o,
  input logic         err_o,
  input logic [W-1:0] shared_cnt_o,
  input logic [W-1:0] vmem_cnt_o
);
  localparam logic [W-1:0] CMAX = '1;

  a_r1_vmem_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_issue_i && !vmem_ret_i && vmem_cnt_o != CMAX)
      |=> vmem_cnt_o == W'($past(vmem_cnt_o) + 1'b1));

  a_r2_vmem_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vmem_issue_i && vmem_ret_i && vmem_cnt_o != '0)
      |=> vmem_cnt_o == W'($past(vmem_cnt_o) - 1'b1));

  a_r2_vmem_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_issue_i && vmem_ret_i && vmem_cnt_o != '0) |=> $stable(vmem_cnt_o));

  a_r4_vmem_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_valid_i && wait_vmem_thr_i != CMAX && vmem_cnt_o > wait_vmem_thr_i) |-> stall_o);

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_issue_i && !vmem_ret_i && vmem_cnt_o == CMAX) |-> stall_o);

  a_r7_hold_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_issue_i && !vmem_ret_i && vmem_cnt_o == CMAX) |=> vmem_cnt_o == CMAX);

  a_r8_zero_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_ret_i && !vmem_issue_i && vmem_cnt_o == '0) |=> (vmem_cnt_o == '0 && err_o));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_valid_i && !scalar_issue_i && !lds_issue_i && !vmem_issue_i) |-> !stall_o);
endmodule

bind wcnt_scoreboard wcnt_scoreboard_chk #(.W(W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .scalar_issue_i   (scalar_issue_i),
  .lds_issue_i      (lds_issue_i),
  .vmem_issue_i     (vmem_issue_i),
  .scalar_ret_i     (scalar_ret_i),
  .lds_ret_i        (lds_ret_i),
  .vmem_ret_i       (vmem_ret_i),
  .wait_valid_i     (wait_valid_i),
  .wait_shared_thr_i(wait_shared_thr_i),
  .wait_vmem_thr_i  (wait_vmem_thr_i),
  .stall_o          (stall_o),
  .err_o            (err_o),
  .shared_cnt_o     (shared_cnt_o),
  .vmem_cnt_o       (vmem_cnt_o)
);

// File: tb/sim_wcnt_scoreboard.sv
module sim_wcnt_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       si = 0, li = 0, vi = 0, sr = 0, lr = 0, vr = 0, wv = 0;
  logic [5:0] ts = 6'd63, tv = 6'd63;
  logic       stall, err;
  logic [5:0] scnt, vcnt;

  int n_chk = 0, n_fail = 0;
  int ms = 0, ml = 0, mv = 0;
  bit merr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wcnt_scoreboard u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .scalar_issue_i(si), .lds_issue_i(li), .vmem_issue_i(vi),
    .scalar_ret_i(sr), .lds_ret_i(lr), .vmem_ret_i(vr),
    .wait_valid_i(wv), .wait_shared_thr_i(ts), .wait_vmem_thr_i(tv),
    .stall_o(stall), .err_o(err), .shared_cnt_o(scnt), .vmem_cnt_o(vcnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_stall();
    int  sok = (sr && ms > 0) ? 1 : 0;
    int  lok = (lr && ml > 0) ? 1 : 0;
    int  vok = (vr && mv > 0) ? 1 : 0;
    bit  sh_blk = (si || li) && (ms + ml + si + li - sok - lok > 63);
    bit  v_blk  = vi && (mv + vi - vok > 63);
    int  eff    = (ms > 0) ? 0 : int'(ts);
    bit  sw     = (ts != 6'd63) && (ms + ml > eff);
    bit  vw     = (tv != 6'd63) && (mv > int'(tv));
    return sh_blk || v_blk || (wv && (sw || vw));
  endfunction

  task automatic model_update();
    int sok = (sr && ms > 0) ? 1 : 0;
    int lok = (lr && ml > 0) ? 1 : 0;
    int vok = (vr && mv > 0) ? 1 : 0;
    bit sh_acc = (ms + ml + si + li - sok - lok) <= 63;
    bit v_acc  = (mv + vi - vok) <= 63;
    if ((sr && !sok) || (lr && !lok) || (vr && !vok)) merr = 1;
    ms = ms + ((si && sh_acc) ? 1 : 0) - sok;
    ml = ml + ((li && sh_acc) ? 1 : 0) - lok;
    mv = mv + ((vi && v_acc) ? 1 : 0) - vok;
  endtask

  // one cycle: drive at negedge, check stall, then counts after the edge
  task automatic step(input bit a, b, c, d, e, f, w, input logic [5:0] t0, t1,
                      input string stag, input string ctag);
    @(negedge clk);
    si = a; li = b; vi = c; sr = d; lr = e; vr = f; wv = w; ts = t0; tv = t1;
    #1;
    check(stall == exp_stall(), stag, int'(stall), int'(exp_stall()));
    model_update();
    @(posedge clk);
    #1;
    check(int'(scnt) == ms + ml, ctag, int'(scnt), ms + ml);
    check(int'(vcnt) == mv, ctag, int'(vcnt), mv);
    check(err == merr, ctag, int'(err), int'(merr));
  endtask

  task automatic idle();
    @(negedge clk);
    {si, li, vi, sr, lr, vr, wv} = '0;
    ts = 6'd63; tv = 6'd63;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    ms = 0; ml = 0; mv = 0; merr = 0;
    repeat (2) @(negedge clk);
    #1;
    check(scnt == 0 && vcnt == 0, "R9 counts", int'(scnt) + int'(vcnt), 0);
    check(err == 0, "R9 err", int'(err), 0);
    check(stall == 0, "R9 stall", int'(stall), 0);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    do_reset();

    // R1 single issues
    step(0,0,1, 0,0,0, 0, 63,63, "R10 stall", "R1 vmem inc");
    step(1,0,0, 0,0,0, 0, 63,63, "R10 stall", "R1 scalar inc");
    step(0,1,0, 0,0,0, 0, 63,63, "R10 stall", "R1 lds inc");
    // R3 both shared classes at once
    step(1,1,0, 0,0,0, 0, 63,63, "R10 stall", "R3 shared +2");
    // R2 same-cycle issue and return
    step(0,0,1, 0,0,1, 0, 63,63, "R10 stall", "R2 vmem same");
    step(0,0,0, 0,0,1, 0, 63,63, "R10 stall", "R2 vmem dec");
    // R6 scalar outstanding: shared thr 3 behaves as 0 (shared=4)
    step(0,0,0, 0,0,0, 1, 3,63, "R6 scalar forces zero", "R6 counts");
    step(0,0,0, 1,0,0, 1, 3,63, "R6 scalar forces zero", "R6 ret");
    step(0,0,0, 1,0,0, 1, 3,63, "R6 scalar forces zero", "R6 ret");
    // scalar now 0, shared=2 <= 3 -> released
    step(0,0,0, 0,0,0, 1, 3,63, "R6 released", "R6 counts");
    step(0,0,0, 0,0,0, 1, 1,63, "R4 shared above thr", "R4 counts");
    // R5 all-ones disables wait
    step(0,0,0, 0,0,0, 1, 63,63, "R5 no wait", "R5 counts");
    step(0,0,1, 0,0,0, 1, 63,0, "R4 vmem above thr", "R4 counts");
    // R7 fill vector count
    for (int i = 0; i < 70; i++)
      step(0,0,1, 0,0,0, 0, 63,63, "R7 saturate stall", "R7 no wrap");
    check(vcnt == 6'd63, "R7 held at max", int'(vcnt), 63);
    step(0,0,1, 0,0,1, 0, 63,63, "R7 issue+ret at max", "R7 count");
    for (int i = 0; i < 64; i++)
      step(0,0,0, 0,0,1, 0, 63,63, "R10 stall", "R2 drain");
    // R8 return at zero
    step(0,0,0, 0,0,1, 0, 63,63, "R10 stall", "R8 zero ret vmem");
    step(0,0,0, 0,1,0, 0, 63,63, "R10 stall", "R8 zero ret lds");
    step(0,0,0, 0,0,0, 0, 63,63, "R10 stall", "R8 sticky");
    check(err == 1, "R8 err set", int'(err), 1);

    do_reset();
    // random phase
    for (int n = 0; n < 3000; n++) begin
      bit a = ($urandom_range(99) < 45);
      bit b = ($urandom_range(99) < 30);
      bit c = ($urandom_range(99) < 50);
      bit d = ($urandom_range(99) < 35);
      bit e = ($urandom_range(99) < 30);
      bit f = ($urandom_range(99) < 40);
      bit w = ($urandom_range(99) < 50);
      logic [5:0] t0 = ($urandom_range(9) == 0) ? 6'd63 : 6'($urandom_range(8));
      logic [5:0] t1 = ($urandom_range(9) == 0) ? 6'd63 : 6'($urandom_range(8));
      step(a,b,c, d,e,f, w, t0,t1, "R4/R6 random stall", "R1/R2 random count");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule